// File: doc/BRIEF.md
# Supply Supervisor Reset Timer

This block watches the host's 5 V rail through two comparator flags. One flag reports that the rail has risen above the upper threshold, which is the trip level plus hysteresis. The other reports that the rail has fallen below the lower trip level. A saturating counter plays the part of the external delay capacitor. It is held at zero until the rail has cleared the upper threshold. After that it charges by one step on every timebase tick. When it reaches its terminal value, the alarm releases and the session sequencer is allowed to run. The pulse width is therefore set by a parameter rather than by a capacitor.

If the rail drops below the lower threshold, the counter is discharged at once and the alarm is raised again. A one-cycle emergency request also tells the card sequencer to deactivate the contacts. This request goes only to the sequencer and is kept apart from the host's fault interrupt. Between the two thresholds, the block keeps whichever condition it was last in. The supervisor has no dependency on the main device supply. Both comparator flags are resynchronised before use.

Top module: `supply_guard`

## Requirements
- R1: After reset, `alarm_hi` is 1, `alarm_lo_n` is 0, `seq_hold` is 1 and `emerg_deact` is 0.
- R2: `alarm_lo_n` is at all times the inverse of `alarm_hi`.
- R3: Until `sup_over_hi` has been seen high, the delay counter stays discharged and the alarm never releases, whatever the tick input does.
- R4: With `tick` held at 1, the alarm releases exactly SYNC_STAGES+1+DELAY_TICKS clock edges after `sup_over_hi` rises, and not one edge earlier.
- R5: `seq_hold` equals `alarm_hi` at all times.
- R6: Once released, the alarm stays released while both comparator flags are low (rail inside the hysteresis band).
- R7: When `sup_under_lo` rises, the alarm is raised SYNC_STAGES+1 edges later. A later recovery needs a full new delay.
- R8: A brown-out that occurs while armed gives exactly one cycle of `emerg_deact`, in the same cycle that the alarm is raised. A low-threshold event while not armed gives none.
- R9: When both flags are high, the low-threshold flag wins: the block discharges and raises the alarm.
- R10: The counter advances only in cycles with `tick`=1. Once armed with `tick` low, the alarm releases DELAY_TICKS edges after `tick` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable for the delay counter |
| sup_over_hi | input | 1 | Comparator: rail above upper (rising) threshold, asynchronous |
| sup_under_lo | input | 1 | Comparator: rail below lower (falling) threshold, asynchronous |
| alarm_hi | output | 1 | Host reset alarm, active high |
| alarm_lo_n | output | 1 | Host reset alarm, active low |
| seq_hold | output | 1 | Blocks the session sequencer while high |
| emerg_deact | output | 1 | One-cycle emergency deactivation request to the card sequencer |

## Verification
A comparator change seen before clock edge E1 passes through the synchroniser by edge E2 and updates the arm flag at E3. With `tick` high, the counter therefore reaches terminal count at E(3+DELAY_TICKS). A brown-out raises the alarm and pulses the emergency request together at E3, and the pulse clears at E4. Each task applies its stimulus at a falling edge and samples half a period after the rising edge in question. Each task checks both the last edge at which the old value must still hold and the edge at which the new value is due, so a result one cycle early or late is caught.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
   // synchronised comparator status
   typedef struct packed {
      logic over_hi;
      logic under_lo;
   } ssr_cmp_t;

   localparam int SSR_CMP_W = $bits(ssr_cmp_t);
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ssr_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("ssr_sync: WIDTH must be at least 1");
      end
   endgenerate

   genvar b;
   generate
      for (b = 0; b < WIDTH; b++) begin : g_bit
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d[b]};
         end
         assign q[b] = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/ssr_arm.sv
module ssr_arm
   import ssr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  ssr_cmp_t cmp,
   output logic     armed,
   output logic     emerg
);
   // hysteresis latch: low flag clears, high flag sets, band holds
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         emerg <= 1'b0;
      end else begin
         emerg <= cmp.under_lo & armed;
         if (cmp.under_lo)     armed <= 1'b0;
         else if (cmp.over_hi) armed <= 1'b1;
      end
   end

   // R8
   emerg_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      emerg |=> !emerg);

   // R8
   emerg_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      emerg |-> !armed);
endmodule

// File: rtl/ssr_delay.sv
module ssr_delay #(
   parameter int DELAY_TICKS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic discharge,
   input  logic tick,
   output logic ready
);
   localparam int CNT_W = $clog2(DELAY_TICKS + 1);
   localparam logic [CNT_W-1:0] TERM = CNT_W'(DELAY_TICKS);

   generate
      if (DELAY_TICKS < 1) begin : g_bad_delay
         $error("ssr_delay: DELAY_TICKS must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (discharge || !armed) cnt <= '0;
      else if (tick && cnt != TERM) cnt <= cnt + 1'b1;
   end

   assign ready = (cnt == TERM);

   // R4
   cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= TERM);

   // R10
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !discharge && !tick) |=> $stable(cnt));

   // R7
   discharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      discharge |=> !ready);
endmodule

// File: rtl/supply_guard.sv
module supply_guard
   import ssr_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DELAY_TICKS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic sup_over_hi,
   input  logic sup_under_lo,
   output logic alarm_hi,
   output logic alarm_lo_n,
   output logic seq_hold,
   output logic emerg_deact
);
   ssr_cmp_t cmp_raw;
   ssr_cmp_t cmp_s;
   logic     armed;
   logic     ready;

   assign cmp_raw.over_hi  = sup_over_hi;
   assign cmp_raw.under_lo = sup_under_lo;

   ssr_sync #(.WIDTH(SSR_CMP_W), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cmp_raw),
      .q     (cmp_s)
   );

   ssr_arm arm_i (
      .clk   (clk),
      .rst_n (rst_n),
      .cmp   (cmp_s),
      .armed (armed),
      .emerg (emerg_deact)
   );

   ssr_delay #(.DELAY_TICKS(DELAY_TICKS)) delay_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .armed     (armed),
      .discharge (cmp_s.under_lo),
      .tick      (tick),
      .ready     (ready)
   );

   assign alarm_hi   = ~ready;
   assign alarm_lo_n = ready;
   assign seq_hold   = ~ready;

   // R9
   prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_s.under_lo |=> alarm_hi);

   // R6
   band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!alarm_hi && !cmp_s.under_lo) |=> !alarm_hi);

   // R3
   unarmed_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> alarm_hi);
endmodule

// File: tb/supply_guard_tb_top.sv
module supply_guard_tb_top;
   localparam int SYNC = 2;
   localparam int TERM = 6;
   localparam int LAT  = SYNC + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b1;
   logic over_hi = 1'b0;
   logic under_lo = 1'b0;
   logic alarm_hi, alarm_lo_n, seq_hold, emerg_deact;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   supply_guard #(.SYNC_STAGES(SYNC), .DELAY_TICKS(TERM)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .sup_over_hi (over_hi),
      .sup_under_lo(under_lo),
      .alarm_hi    (alarm_hi),
      .alarm_lo_n  (alarm_lo_n),
      .seq_hold    (seq_hold),
      .emerg_deact (emerg_deact)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%0b exp=%0b", req, what, act, exp);
      end
   endtask

   // alarm in both polarities plus sequencer hold (R2, R5)
   task automatic chk_alarm(input string req, input logic exp);
      chk(req, "alarm_hi", alarm_hi, exp);
      chk("R2", "alarm_lo_n", alarm_lo_n, ~exp);
      chk("R5", "seq_hold", seq_hold, exp);
   endtask

   // called at a negedge; returns at the negedge after the n-th rising edge
   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk_alarm("R1", 1'b1);
      chk("R1", "emerg", emerg_deact, 1'b0);
   endtask

   task automatic t_powerup;
      over_hi = 1'b1;
      edges(LAT + TERM - 1);
      chk_alarm("R4", 1'b1);
      edges(1);
      chk_alarm("R4", 1'b0);
      chk("R4", "emerg", emerg_deact, 1'b0);
   endtask

   task automatic t_band;
      over_hi = 1'b0;
      under_lo = 1'b0;
      for (int i = 0; i < 12; i++) begin
         edges(1);
         chk_alarm("R6", 1'b0);
      end
   endtask

   task automatic t_brownout;
      over_hi = 1'b0;
      under_lo = 1'b1;
      edges(LAT - 1);
      chk_alarm("R7", 1'b0);
      chk("R8", "emerg early", emerg_deact, 1'b0);
      edges(1);
      chk_alarm("R7", 1'b1);
      chk("R8", "emerg pulse", emerg_deact, 1'b1);
      edges(1);
      chk("R8", "emerg end", emerg_deact, 1'b0);
   endtask

   task automatic t_unarmed_low;
      under_lo = 1'b0;
      edges(4);
      under_lo = 1'b1;
      for (int i = 0; i < 6; i++) begin
         edges(1);
         chk("R8", "emerg unarmed", emerg_deact, 1'b0);
      end
      under_lo = 1'b0;
      edges(4);
      chk("R8", "emerg unarmed", emerg_deact, 1'b0);
   endtask

   task automatic t_band_discharged;
      over_hi = 1'b0;
      under_lo = 1'b0;
      edges(3 * TERM);
      chk_alarm("R3", 1'b1);
      over_hi = 1'b1;
      edges(LAT + TERM - 1);
      chk_alarm("R7", 1'b1);
      edges(1);
      chk_alarm("R7", 1'b0);
   endtask

   task automatic t_priority;
      over_hi = 1'b1;
      under_lo = 1'b1;
      edges(LAT);
      chk_alarm("R9", 1'b1);
      chk("R9", "emerg", emerg_deact, 1'b1);
      edges(1);
      chk("R9", "emerg end", emerg_deact, 1'b0);
      chk_alarm("R9", 1'b1);
      under_lo = 1'b0;
      edges(LAT + TERM - 1);
      chk_alarm("R9", 1'b1);
      edges(1);
      chk_alarm("R9", 1'b0);
   endtask

   task automatic t_tick_gate;
      over_hi = 1'b0;
      under_lo = 1'b1;
      edges(LAT + 2);
      chk_alarm("R10", 1'b1);
      tick = 1'b0;
      under_lo = 1'b0;
      over_hi = 1'b1;
      edges(LAT + TERM + 5);
      chk_alarm("R10", 1'b1);
      tick = 1'b1;
      edges(TERM - 1);
      chk_alarm("R10", 1'b1);
      edges(1);
      chk_alarm("R10", 1'b0);
   endtask

   initial begin
      edges(3);
      rst_n = 1'b1;
      edges(1);
      t_reset();
      t_powerup();
      t_band();
      t_brownout();
      t_unarmed_low();
      t_band_discharged();
      t_priority();
      t_tick_gate();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule